// File: doc/BRIEF.md
# Supervisory reset pulse generator

This block merges the conditions that should hold a processor in reset into one reset pulse with a guaranteed minimum width. The sources are a synchronous power-fail flag from an external supply comparator, an active-low pushbutton, and a timeout request from a watchdog. While any source is active the reset is held. Once every source has gone quiet, the reset stays asserted for a further stretch interval of at least `STRETCH_MS` milliseconds before it lets go. Both polarities of the reset are driven.

The pushbutton is an asynchronous input. It first passes through a synchronizer and is then debounced: a level change counts only after it has held for `DEBOUNCE_MS` milliseconds. Timing is based on a one-millisecond tick, divided down from the clock frequency given by `CLK_HZ`. The tolerance select input does not affect the reset logic. It is routed straight to the comparator's threshold control, where it chooses between the 5% and 10% trip levels below a 5 V rail.

Top module: `supv_reset`

## Requirements
- R1: While `pwr_fail_i` is 1, `rst_o` is 1 from the following clock cycle onward.
- R2: After `pwr_fail_i` returns to 0, `rst_o` stays at 1 for at least `STRETCH_MS` ms of clock cycles, and releases no more than 2 ms of cycles after that bound.
- R3: `pb_n_i` is active low. A debounced press (level 0) asserts `rst_o` and holds it for the whole press. A level of 1 has no effect.
- R4: A low on `pb_n_i` shorter than `DEBOUNCE_MS - 1` ms is ignored and leaves `rst_o` at 0.
- R5: For a pushbutton press, the stretch interval is measured from the release. `rst_o` stays at 1 for at least `STRETCH_MS` ms after `pb_n_i` returns to 1.
- R6: `rst_n_o` is always the complement of `rst_o`.
- R7: `tol_sel_o` follows `tol_sel_i` in the same cycle, with 0 selecting the 5% trip level and 1 selecting the 10% trip level.
- R8: A 1 on `wdt_req_i`, even for a single cycle, asserts `rst_o` in the next cycle and holds it for at least `STRETCH_MS` ms after the request drops.
- R9: A new fault, press or request during a stretch restarts the stretch. Release then comes no earlier than `STRETCH_MS` ms after the new event ends.
- R10: While `rst` is 1 and after it drops, `rst_o` is 1. It stays at 1 for at least `STRETCH_MS` ms after `rst` returns to 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock at `CLK_HZ` |
| rst | input | 1 | Synchronous active-high system reset |
| pwr_fail_i | input | 1 | Power-fail flag from the supply comparator, synchronous, 1 = out of tolerance |
| tol_sel_i | input | 1 | Trip level select, 0 = 5%, 1 = 10% |
| pb_n_i | input | 1 | Pushbutton, asynchronous, 0 = pressed |
| wdt_req_i | input | 1 | Watchdog timeout reset request, 1 = request |
| tol_sel_o | output | 1 | Trip level select forwarded to the comparator |
| rst_o | output | 1 | Reset, active high |
| rst_n_o | output | 1 | Reset, active low |

## Verification
The bench targets the release edge of each source. A design that started the stretch on assertion rather than on release would let go of the reset too early after a long power fault or a long press. A design that ignored events arriving mid-stretch would release early on a retriggered fault. It also checks that a single-cycle watchdog pulse yields a full pulse, that a short button bounce never reaches the output, and that the power-on stretch runs in full. A design that skipped the debounce or the power-on stretch would fail these checks.

// File: rtl/supv_pkg.sv
package supv_pkg;

    // Current phase of the reset stretcher
    typedef enum logic [1:0] {
        SV_IDLE    = 2'd0,
        SV_HOLD    = 2'd1,
        SV_STRETCH = 2'd2
    } sv_state_e;

    // Conditions that hold the reset
    typedef struct packed {
        logic pwr;
        logic btn;
        logic wdt;
    } hold_src_t;

    // Number of clock cycles in one millisecond, never less than one
    function automatic int unsigned ms_div(input int unsigned clk_hz);
        int unsigned d;
        d = clk_hz / 1000;
        return (d == 0) ? 1 : d;
    endfunction

    // Width of a counter that holds the values 0..n-1
    function automatic int unsigned cnt_w(input int unsigned n);
        return (n <= 2) ? 1 : $clog2(n);
    endfunction

    // Tick count that guarantees a full window: the first tick may land early
    function automatic int unsigned full_ticks(input int unsigned ms);
        return ms + 1;
    endfunction

    // True when any source wants the reset held
    function automatic logic any_hold(input hold_src_t s);
        return s.pwr | s.btn | s.wdt;
    endfunction

endpackage

// File: rtl/supv_ms_tick.sv
module supv_ms_tick #(
    parameter int unsigned DIV = 1000
) (
    input  logic clk,
    input  logic rst,
    output logic tick
);
    import supv_pkg::*;

    generate
        if (DIV <= 1) begin : g_every
            assign tick = 1'b1;
        end else begin : g_div
            localparam int unsigned W = cnt_w(DIV);
            localparam logic [W-1:0] LAST = W'(DIV - 1);
            logic [W-1:0] phase_q;

            always_ff @(posedge clk) begin
                if (rst) begin
                    phase_q <= '0;
                end else if (phase_q == LAST) begin
                    phase_q <= '0;
                end else begin
                    phase_q <= phase_q + 1'b1;
                end
            end

            assign tick = (phase_q == LAST);
        end
    endgenerate

endmodule

// File: rtl/supv_debounce.sv
module supv_debounce #(
    parameter int unsigned SYNC_STAGES = 2,
    parameter int unsigned DEB_TICKS   = 20
) (
    input  logic clk,
    input  logic rst,
    input  logic tick,
    input  logic btn_n,
    output logic pressed
);
    import supv_pkg::*;

    localparam int unsigned CW = cnt_w(DEB_TICKS);
    localparam logic [CW-1:0] LAST = CW'(DEB_TICKS - 1);

    logic [SYNC_STAGES-1:0] sync_q;
    logic                   btn_s;
    logic                   level_q;   // accepted level, 1 = released
    logic [CW-1:0]          run_q;

    // Synchronizer chain, idles at the released level
    generate
        for (genvar i = 0; i < SYNC_STAGES; i++) begin : g_sync
            if (i == 0) begin : g_first
                always_ff @(posedge clk) begin
                    if (rst) sync_q[0] <= 1'b1;
                    else     sync_q[0] <= btn_n;
                end
            end else begin : g_next
                always_ff @(posedge clk) begin
                    if (rst) sync_q[i] <= 1'b1;
                    else     sync_q[i] <= sync_q[i-1];
                end
            end
        end
    endgenerate

    assign btn_s = sync_q[SYNC_STAGES-1];

    // A new level is accepted once it has differed for DEB_TICKS ticks
    always_ff @(posedge clk) begin
        if (rst) begin
            level_q <= 1'b1;
            run_q   <= '0;
        end else if (btn_s == level_q) begin
            run_q <= '0;
        end else if (tick) begin
            if (run_q == LAST) begin
                level_q <= btn_s;
                run_q   <= '0;
            end else begin
                run_q <= run_q + 1'b1;
            end
        end
    end

    assign pressed = ~level_q;

endmodule

// File: rtl/supv_stretch.sv
module supv_stretch #(
    parameter int unsigned STRETCH_TICKS = 251
) (
    input  logic                clk,
    input  logic                rst,
    input  logic                tick,
    input  supv_pkg::hold_src_t src,
    output logic                active
);
    import supv_pkg::*;

    localparam int unsigned CW = cnt_w(STRETCH_TICKS);
    localparam logic [CW-1:0] LAST = CW'(STRETCH_TICKS - 1);

    sv_state_e     state_q;
    logic [CW-1:0] cnt_q;
    logic          hold;

    assign hold = any_hold(src);

    always_ff @(posedge clk) begin
        if (rst) begin
            // Come up in reset and run a full stretch
            state_q <= SV_STRETCH;
            cnt_q   <= '0;
        end else if (hold) begin
            state_q <= SV_HOLD;
            cnt_q   <= '0;
        end else if (state_q != SV_IDLE) begin
            state_q <= SV_STRETCH;
            if (tick) begin
                if (cnt_q == LAST) begin
                    state_q <= SV_IDLE;
                    cnt_q   <= '0;
                end else begin
                    cnt_q <= cnt_q + 1'b1;
                end
            end
        end
    end

    assign active = (state_q != SV_IDLE);

endmodule

// File: rtl/supv_reset.sv
module supv_reset #(
    parameter int unsigned CLK_HZ      = 1_000_000,
    parameter int unsigned STRETCH_MS  = 250,
    parameter int unsigned DEBOUNCE_MS = 20
) (
    input  logic clk,
    input  logic rst,
    input  logic pwr_fail_i,
    input  logic tol_sel_i,
    input  logic pb_n_i,
    input  logic wdt_req_i,
    output logic tol_sel_o,
    output logic rst_o,
    output logic rst_n_o
);
    import supv_pkg::*;

    localparam int unsigned TICK_DIV      = ms_div(CLK_HZ);
    localparam int unsigned STRETCH_TICKS = full_ticks(STRETCH_MS);

    logic      ms_tick;
    logic      btn_pressed;
    logic      rst_act;
    hold_src_t src;

    supv_ms_tick #(.DIV(TICK_DIV)) u_tick (
        .clk  (clk),
        .rst  (rst),
        .tick (ms_tick)
    );

    supv_debounce #(.SYNC_STAGES(2), .DEB_TICKS(DEBOUNCE_MS)) u_deb (
        .clk     (clk),
        .rst     (rst),
        .tick    (ms_tick),
        .btn_n   (pb_n_i),
        .pressed (btn_pressed)
    );

    always_comb begin
        src.pwr = pwr_fail_i;
        src.btn = btn_pressed;
        src.wdt = wdt_req_i;
    end

    supv_stretch #(.STRETCH_TICKS(STRETCH_TICKS)) u_str (
        .clk    (clk),
        .rst    (rst),
        .tick   (ms_tick),
        .src    (src),
        .active (rst_act)
    );

    assign rst_o     = rst_act;
    assign rst_n_o   = ~rst_act;
    assign tol_sel_o = tol_sel_i;

endmodule

// File: rtl/supv_reset_chk.sv
module supv_reset_chk #(
    parameter int unsigned CLK_HZ      = 1_000_000,
    parameter int unsigned STRETCH_MS  = 250,
    parameter int unsigned DEBOUNCE_MS = 20
) (
    input logic clk,
    input logic rst,
    input logic pwr_fail_i,
    input logic pb_n_i,
    input logic wdt_req_i,
    input logic btn_pressed,
    input logic rst_o,
    input logic rst_n_o
);
    localparam int unsigned DIV      = supv_pkg::ms_div(CLK_HZ);
    localparam int unsigned MIN_QUIET = STRETCH_MS * DIV - 1;
    localparam int unsigned MIN_LOW   = (DEBOUNCE_MS - 1) * DIV;

    logic [31:0] quiet_q;
    logic [31:0] low_q;

    always_ff @(posedge clk) begin
        if (rst || pwr_fail_i || wdt_req_i || btn_pressed) quiet_q <= '0;
        else if (quiet_q != 32'hFFFF_FFFF)                 quiet_q <= quiet_q + 1;
    end

    always_ff @(posedge clk) begin
        if (rst || pb_n_i)               low_q <= '0;
        else if (low_q != 32'hFFFF_FFFF) low_q <= low_q + 1;
    end

    AST_PF_HOLDS: assert property (@(posedge clk) disable iff (rst)
        pwr_fail_i |=> rst_o); // R1

    AST_MIN_WIDTH: assert property (@(posedge clk) disable iff (rst)
        $fell(rst_o) |-> (quiet_q >= MIN_QUIET)); // R2

    AST_PRESS_HOLDS: assert property (@(posedge clk) disable iff (rst)
        btn_pressed |=> rst_o); // R3

    AST_DEBOUNCE: assert property (@(posedge clk) disable iff (rst)
        $rose(btn_pressed) |-> (low_q >= MIN_LOW)); // R4

    AST_COMPLEMENT: assert property (@(posedge clk) disable iff (rst)
        rst_o != rst_n_o); // R6

    AST_WDT_HOLDS: assert property (@(posedge clk) disable iff (rst)
        wdt_req_i |=> rst_o); // R8

endmodule

bind supv_reset supv_reset_chk #(
    .CLK_HZ      (CLK_HZ),
    .STRETCH_MS  (STRETCH_MS),
    .DEBOUNCE_MS (DEBOUNCE_MS)
) u_chk (
    .clk         (clk),
    .rst         (rst),
    .pwr_fail_i  (pwr_fail_i),
    .pb_n_i      (pb_n_i),
    .wdt_req_i   (wdt_req_i),
    .btn_pressed (btn_pressed),
    .rst_o       (rst_o),
    .rst_n_o     (rst_n_o)
);

// File: tb/supv_reset_bench.sv
module supv_reset_bench;
    localparam int CLK_PERIOD = 10;
    localparam int CLK_HZ     = 10_000;
    localparam int DIV        = CLK_HZ / 1000;
    localparam int STR_MS     = 250;
    localparam int DEB_MS     = 20;
    localparam int WD_LIMIT   = 150_000;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic pf = 1'b0, tol = 1'b0, pb_n = 1'b1, wdt = 1'b0;
    logic tol_o, r_o, rn_o;

    int n_chk = 0, n_fail = 0, cyc = 0;
    bit done = 0;

    // behavioural reference state
    int m_phase, m_dc, m_sc;
    bit m_s1, m_s2, m_db, m_rst;

    always #(CLK_PERIOD/2) clk = ~clk;

    supv_reset #(.CLK_HZ(CLK_HZ), .STRETCH_MS(STR_MS), .DEBOUNCE_MS(DEB_MS)) u_supv_reset (
        .clk(clk), .rst(rst), .pwr_fail_i(pf), .tol_sel_i(tol), .pb_n_i(pb_n),
        .wdt_req_i(wdt), .tol_sel_o(tol_o), .rst_o(r_o), .rst_n_o(rn_o)
    );

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d (cycle %0d)", req, act, exp, cyc);
        end
    endtask

    // reference model: hold while a source is active, then wait STR_MS+1 ms ticks
    always @(posedge clk) begin
        bit t, hold;
        cyc++;
        if (rst) begin
            m_phase = 0; m_dc = 0; m_sc = 0;
            m_s1 = 1; m_s2 = 1; m_db = 1; m_rst = 1;
        end else begin
            t = (m_phase == DIV - 1);
            hold = pf || wdt || !m_db;
            if (hold) begin
                m_rst = 1; m_sc = 0;
            end else if (m_rst && t) begin
                if (m_sc == STR_MS) begin m_rst = 0; m_sc = 0; end
                else m_sc++;
            end
            if (m_s2 == m_db) m_dc = 0;
            else if (t) begin
                if (m_dc == DEB_MS - 1) begin m_db = m_s2; m_dc = 0; end
                else m_dc++;
            end
            m_s2 = m_s1; m_s1 = pb_n;
            m_phase = (m_phase + 1) % DIV;
        end
    end

    // compare every cycle away from the active edge
    always @(negedge clk) begin
        if (!done) begin
            chk(r_o == m_rst, "R1 R2 R3 R5 R8 R9 R10 model", int'(r_o), int'(m_rst));
            chk(rn_o == !r_o, "R6", int'(rn_o), int'(!r_o));
            chk(tol_o == tol, "R7", int'(tol_o), int'(tol));
        end
    end

    task automatic step(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic measure(input int t0, input int hi_extra, input string req);
        int d;
        for (int i = 0; i < 6000 && r_o; i++) @(negedge clk);
        d = cyc - t0;
        chk(d >= STR_MS * DIV && d <= (STR_MS + hi_extra) * DIV, req, d, STR_MS * DIV);
    endtask

    task automatic finish_run;
        done = 1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    endtask

    initial begin
        step(5);
        chk(r_o == 1 && rn_o == 0, "R10 reset state", int'(r_o), 1);
        rst = 1'b0;
        measure(cyc, 2, "R10 power-on stretch");

        // R7 trip select forwarding
        tol = 1'b1; step(1); chk(tol_o == 1, "R7 10% select", int'(tol_o), 1);
        tol = 1'b0; step(1); chk(tol_o == 0, "R7 5% select", int'(tol_o), 0);

        // R1 / R2 long power fault
        pf = 1'b1; step(2);
        chk(r_o == 1, "R1 fault asserts", int'(r_o), 1);
        step(600);
        chk(r_o == 1 && rn_o == 0, "R1 held during fault", int'(r_o), 1);
        pf = 1'b0;
        measure(cyc, 2, "R2 stretch after fault");

        // R4 short bounce ignored
        pb_n = 1'b0; step(50); pb_n = 1'b1;
        step(400);
        chk(r_o == 0, "R4 bounce ignored", int'(r_o), 0);

        // R3 / R5 long press, stretch from release
        pb_n = 1'b0; step(DEB_MS * DIV + 20);
        chk(r_o == 1, "R3 press asserts", int'(r_o), 1);
        step(1500);
        chk(r_o == 1, "R5 held during press", int'(r_o), 1);
        pb_n = 1'b1;
        measure(cyc, DEB_MS + 3, "R5 stretch after release");

        // R8 single-cycle watchdog request
        wdt = 1'b1; step(1); wdt = 1'b0; step(1);
        chk(r_o == 1, "R8 request asserts", int'(r_o), 1);
        measure(cyc - 1, 2, "R8 request stretch");

        // R9 retrigger during stretch
        pf = 1'b1; step(30); pf = 1'b0;
        step(1200);
        chk(r_o == 1, "R9 mid-stretch", int'(r_o), 1);
        pf = 1'b1; step(10); pf = 1'b0;
        measure(cyc, 2, "R9 restart after second fault");

        // R9 watchdog retrigger
        pf = 1'b1; step(5); pf = 1'b0; step(2000);
        wdt = 1'b1; step(1); wdt = 1'b0;
        measure(cyc, 2, "R9 restart after request");

        step(20);
        finish_run();
    end

    initial begin
        repeat (WD_LIMIT) @(posedge clk);
        n_chk++; n_fail++;
        $display("FAIL watchdog: actual %0d expected %0d", WD_LIMIT, 0);
        finish_run();
    end

endmodule